// File: doc/BRIEF.md
# Radix-2 Sixteen-Point Transform Pass Sequencer

This block is the control engine for an in-place, radix-2, sixteen-point Fourier transform. It stores no samples and does no arithmetic. After a start pulse it walks through four passes of eight butterflies each, one butterfly per clock. In every butterfly cycle it presents two memory addresses (`j`, the upper input, and `k`, the lower input) and a twiddle index `m`. A shared sample memory and a butterfly unit beside it consume these values. When no transform is running, `done` is high.

The machine has two states, Idle and Run. Idle holds the pass and butterfly counters at zero. An asserted `start` in Idle takes the transition Idle→Run. Run advances the 3-bit butterfly counter every cycle. When the counter wraps, the 2-bit pass counter steps. When the last butterfly of the last pass completes, the transition Run→Idle is taken. The synchronous clear `clr` forces Idle from either state.

The two addresses are not built from nested loops. Each is the butterfly count with one extra bit inserted. For `j` that bit is 0 and for `k` it is 1. Its position equals the pass number. The twiddle index is the count shifted left by three minus the pass number and kept to three bits.

Top module: `fft_pass_seq`

## Requirements
- R1: While `clr` is high at a rising edge, the next state is Idle with `pass`=0 and `count`=0, and `done` reads 1 after that edge. This holds even while a transform is running.
- R2: In Idle with `start` low, `pass` and `count` stay 0 and `done` stays 1.
- R3: A `start` sampled high in Idle moves the machine to Run at that edge. The first Run cycle shows `pass`=0, `count`=0 and `done`=0.
- R4: In Run, `count` increases by 1 every cycle. When `count` is 7, it wraps to 0 and `pass` increases by 1.
- R5: The Run cycle with `pass`=3 and `count`=7 is the last one. Run lasts exactly 32 cycles, then Idle follows. If `start` is still high in that Idle cycle, a new Run begins on the next cycle.
- R6: `done` is 1 exactly when the state is Idle.
- R7: In pass 0, `j` = {count, 0} and `k` = {count, 1}. Bit 0 is the inserted bit.
- R8: In pass 1, `j` = {count[2:1], 0, count[0]}. The first four (j, k, m) triples are (0,2,0), (1,3,4), (4,6,0), (5,7,4).
- R9: In pass 2, `j` = {count[2], 0, count[1:0]}. In pass 3, `j` = {0, count}.
- R10: `k` equals `j` with the inserted bit (bit number `pass`) set to 1. So `j` and `k` differ in exactly that one bit.
- R11: `m` = (count << (3 − pass)) mod 8.
- R12: A `start` pulse during Run does not change the sequence of `pass`/`count` or the cycle in which Run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear to Idle |
| start | input | 1 | Begin a transform (sampled in Idle) |
| pass | output | 2 | Current pass number |
| count | output | 3 | Butterfly number within the pass |
| j | output | 4 | Address of the upper butterfly input |
| k | output | 4 | Address of the lower butterfly input |
| m | output | 3 | Twiddle factor index |
| done | output | 1 | High while idle |

## Verification
A full 32-cycle run is compared against an arithmetic model of bit insertion and twiddle shifting. This covers all four passes, so an error in the insertion position for any single pass shows up. The literal pass-1 triples tell a wrong bit position apart from a wrong shift amount. A start pulse injected mid-run, a clear injected mid-run and a start held high across the end of a run separate the three ways of leaving or re-entering Run. These are ignoring `start`, aborting on `clr`, and the single-cycle Idle between back-to-back runs.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/fft_seq_ctrl.sv
module fft_seq_ctrl
    import fft_seq_pkg::*;
#(
    parameter int PASS_W    = 2,
    parameter int CNT_W     = 3,
    parameter int LAST_PASS = 3
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              start,
    output logic [PASS_W-1:0] pass_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              idle
);
    localparam logic [CNT_W-1:0]  CNT_LAST  = '1;
    localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(LAST_PASS);

    seq_state_e state_q, state_d;
    logic       last_bfly;

    assign last_bfly = (cnt_q == CNT_LAST) && (pass_q == PASS_LAST);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: state_d = start ? SEQ_RUN : SEQ_IDLE;
            SEQ_RUN:  state_d = last_bfly ? SEQ_IDLE : SEQ_RUN;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (clr) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    // pass / butterfly counters
    always_ff @(posedge clk) begin
        if (clr || state_q == SEQ_IDLE) begin
            pass_q <= '0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) pass_q <= pass_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            SEQ_IDLE: idle = 1'b1;
            SEQ_RUN:  idle = 1'b0;
            default:  idle = 1'b1;
        endcase
    end

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (clr)
        (state_q == SEQ_RUN && cnt_q != CNT_LAST) |=>
            (cnt_q == CNT_W'($past(cnt_q) + 1'b1) && pass_q == $past(pass_q)));

    // R4
    pass_step_chk: assert property (@(posedge clk) disable iff (clr)
        (state_q == SEQ_RUN && cnt_q == CNT_LAST && pass_q != PASS_LAST) |=>
            (cnt_q == '0 && pass_q == PASS_W'($past(pass_q) + 1'b1)));

    // R5
    run_end_chk: assert property (@(posedge clk) disable iff (clr)
        (state_q == SEQ_RUN && last_bfly) |=> (state_q == SEQ_IDLE));

    // R12
    run_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (state_q == SEQ_RUN && !last_bfly) |=> (state_q == SEQ_RUN));
endmodule

// File: rtl/fft_addr_ins.sv
module fft_addr_ins #(
    parameter int   PASS_W = 2,
    parameter int   CNT_W  = 3,
    parameter logic INS    = 1'b0
) (
    input  logic [PASS_W-1:0] pass_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [CNT_W:0]    addr_o
);
    localparam int ADDR_W = CNT_W + 1;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        if (b == 0) begin : g_lsb
            assign addr_o[b] = (int'(pass_i) == 0) ? INS : cnt_i[0];
        end else if (b == ADDR_W - 1) begin : g_msb
            assign addr_o[b] = (int'(pass_i) == b) ? INS : cnt_i[b-1];
        end else begin : g_mid
            assign addr_o[b] = (int'(pass_i) > b)  ? cnt_i[b] :
                               (int'(pass_i) == b) ? INS : cnt_i[b-1];
        end
    end
endmodule

// File: rtl/fft_twiddle_idx.sv
module fft_twiddle_idx #(
    parameter int PASS_W = 2,
    parameter int CNT_W  = 3
) (
    input  logic [PASS_W-1:0] pass_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [CNT_W-1:0]  m_o
);
    int shamt;

    always_comb begin
        shamt = CNT_W - int'(pass_i);
        m_o   = cnt_i << shamt;
    end
endmodule

// File: rtl/fft_pass_seq.sv
module fft_pass_seq #(
    parameter int LOG2N = 4
) (
    input  logic                       clk,
    input  logic                       clr,
    input  logic                       start,
    output logic [$clog2(LOG2N)-1:0]   pass,
    output logic [LOG2N-2:0]           count,
    output logic [LOG2N-1:0]           j,
    output logic [LOG2N-1:0]           k,
    output logic [LOG2N-2:0]           m,
    output logic                       done
);
    localparam int CNT_W  = LOG2N - 1;
    localparam int PASS_W = $clog2(LOG2N);

    fft_seq_ctrl #(.PASS_W(PASS_W), .CNT_W(CNT_W), .LAST_PASS(LOG2N - 1)) u_ctrl (
        .clk(clk), .clr(clr), .start(start),
        .pass_q(pass), .cnt_q(count), .idle(done)
    );

    fft_addr_ins #(.PASS_W(PASS_W), .CNT_W(CNT_W), .INS(1'b0)) u_jgen (
        .pass_i(pass), .cnt_i(count), .addr_o(j)
    );

    fft_addr_ins #(.PASS_W(PASS_W), .CNT_W(CNT_W), .INS(1'b1)) u_kgen (
        .pass_i(pass), .cnt_i(count), .addr_o(k)
    );

    fft_twiddle_idx #(.PASS_W(PASS_W), .CNT_W(CNT_W)) u_twid (
        .pass_i(pass), .cnt_i(count), .m_o(m)
    );

    // R10
    pair_bit_chk: assert property (@(posedge clk) disable iff (clr)
        ($countones(j ^ k) == 1) && (j < k));

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (clr)
        done |-> (pass == '0 && count == '0));

    // R3
    launch_chk: assert property (@(posedge clk) disable iff (clr)
        (done && start) |=> !done);
endmodule

// File: tb/sim_fft_pass_seq.sv
module sim_fft_pass_seq;
    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       start = 1'b0;
    logic [1:0] pass;
    logic [2:0] count;
    logic [3:0] j, k;
    logic [2:0] m;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fft_pass_seq u0 (
        .clk(clk), .clr(clr), .start(start), .pass(pass), .count(count),
        .j(j), .k(k), .m(m), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int addr_model(input int p, input int c, input int ins);
        return ((c >> p) << (p + 1)) + (ins << p) + (c % (1 << p));
    endfunction

    // checks one Run cycle at index t (0..31)
    task automatic check_step(input int t);
        int p = t / 8;
        int c = t % 8;
        chk("R6 done low in Run", int'(done), 0);
        chk("R4 pass", int'(pass), p);
        chk("R4 count", int'(count), c);
        if (p == 0) chk("R7 j", int'(j), c * 2);
        else if (p == 1) chk("R8 j", int'(j), addr_model(1, c, 0));
        else chk("R9 j", int'(j), addr_model(p, c, 0));
        chk("R10 k", int'(k), addr_model(p, c, 1));
        chk("R11 m", int'(m), (c << (3 - p)) % 8);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic t_reset();
        clr = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 done after clear", int'(done), 1);
        chk("R1 pass after clear", int'(pass), 0);
        chk("R1 count after clear", int'(count), 0);
        clr = 1'b0;
    endtask

    task automatic t_idle_hold();
        repeat (4) @(negedge clk);
        chk("R2 done idle", int'(done), 1);
        chk("R2 pass idle", int'(pass), 0);
        chk("R2 count idle", int'(count), 0);
        chk("R6 done idle", int'(done), 1);
    endtask

    task automatic t_full_run();
        pulse_start();
        chk("R3 first cycle done", int'(done), 0);
        for (int t = 0; t < 32; t++) begin
            check_step(t);
            if (t == 8)  chk("R8 triple0", {int'(j), int'(k), int'(m)} == {0, 2, 0} ? 1 : 0, 1);
            if (t == 9)  chk("R8 triple1", {int'(j), int'(k), int'(m)} == {1, 3, 4} ? 1 : 0, 1);
            if (t == 10) chk("R8 triple2", {int'(j), int'(k), int'(m)} == {4, 6, 0} ? 1 : 0, 1);
            if (t == 11) chk("R8 triple3", {int'(j), int'(k), int'(m)} == {5, 7, 4} ? 1 : 0, 1);
            @(negedge clk);
        end
        chk("R5 done after 32", int'(done), 1);
        chk("R5 pass back to 0", int'(pass), 0);
        @(negedge clk);
        chk("R2 stays idle", int'(done), 1);
    endtask

    task automatic t_start_ignored();
        pulse_start();
        for (int t = 0; t < 32; t++) begin
            if (t == 5) start = 1'b1;
            if (t == 6) start = 1'b0;
            chk("R12 done low", int'(done), 0);
            chk("R12 count", int'(count), t % 8);
            chk("R12 pass", int'(pass), t / 8);
            @(negedge clk);
        end
        chk("R12 end cycle unchanged", int'(done), 1);
    endtask

    task automatic t_clear_abort();
        pulse_start();
        repeat (10) @(negedge clk);
        chk("R1 running before clear", int'(done), 0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R1 abort done", int'(done), 1);
        chk("R1 abort pass", int'(pass), 0);
        chk("R1 abort count", int'(count), 0);
        @(negedge clk);
        chk("R1 still idle", int'(done), 1);
    endtask

    task automatic t_back_to_back();
        @(negedge clk) start = 1'b1;
        @(negedge clk);
        for (int t = 0; t < 32; t++) begin
            chk("R5 b2b run", int'(done), 0);
            @(negedge clk);
        end
        chk("R5 one idle cycle", int'(done), 1);
        @(negedge clk);
        start = 1'b0;
        chk("R5 restart done", int'(done), 0);
        chk("R5 restart count", int'(count), 0);
        chk("R5 restart pass", int'(pass), 0);
        check_step(0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        t_reset();
        t_idle_hold();
        t_full_run();
        t_start_ignored();
        t_clear_abort();
        t_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule